// File: doc/BRIEF.md
# Analog Front-End Configuration Register

This block is the register-mapped control point for the analog front end of a remote I/O node. A small register bus (address, write data, write strobe, combinational read data) reaches a configuration word and a conversion-result word. The configuration word holds three things. The first is a 3-bit switch code, decoded into one-hot close commands for six analog switches. The second is a 3-bit monitor-mux field that routes comparator levels onto monitor pins. The third is a conversion-start bit that is written but never read back.

A conversion request goes out to an external converter as a single-cycle start pulse. The block then stays busy until the converter answers with a one-cycle done pulse. On that pulse the converter's result is captured into the read-only result word and the request clears itself. A request can come either from the start bit of the configuration word or from any write addressed to the result word. Requests that arrive while a conversion is running are dropped.

Top module: `anacfg_regs`

## Requirements
- R1: A switch code of 1 through 6 (configuration word bits [2:0]) closes exactly one switch: code k drives `sw_close` bit k-1 high and all other bits low.
- R2: Switch codes 0 and 7 close no switch (`sw_close` is all zero).
- R3: For each monitor pin i, `mon_active[i]` is high only when mux bit i (configuration bits [5:3]) and `pin_oe[i]` are both 1. In that case `mon_out[i]` follows `cmp_in[i]`. Otherwise `mon_out[i]` is 0.
- R4: Reading address 5 returns the comparator levels in bits [5:3] and 0 in every other bit. The switch, mux and start fields always read as 0.
- R5: Writing address 5 with bit 7 set while idle produces exactly one `conv_start` pulse of one cycle, in the cycle after the write, and makes the block busy.
- R6: A write to address 8 with any data starts a conversion exactly as R5 does.
- R7: A start request (R5 or R6) made while busy produces no `conv_start` pulse.
- R8: A `conv_done` pulse while busy ends the busy state and captures `conv_data`. From the next cycle, that value reads back at address 8. A `conv_done` pulse while idle leaves the result unchanged.
- R9: After reset all switches are open, all mux bits are clear, `conv_start` is low, the block is idle and address 8 reads 0.
- R10: Writes to addresses other than 5 and 8 change no output and start no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_in | input | 3 | Comparator output levels |
| pin_oe | input | 3 | Output enables of the three monitor pins |
| sw_close | output | 6 | One-hot close commands for switches S1..S6 |
| mon_active | output | 3 | Monitor pin i is driven by a comparator |
| mon_out | output | 3 | Comparator level routed to monitor pin i |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_done | input | 1 | One-cycle conversion finished pulse |
| conv_data | input | 8 | Converter result, valid with `conv_done` |

## Verification
The assertions assume that `conv_done` is a single-cycle pulse, that it arrives only after a start pulse, and that each write lasts one clock. The bench keeps to this. Every write drives `bus_we` for exactly one cycle. `conv_done` is pulsed for one cycle, mostly during a running conversion. The one exception is a deliberate idle pulse used to show that such a pulse has no effect on the result. All comparator, enable and mux inputs are changed only between clock edges.

// File: rtl/anacfg_pkg.sv
package anacfg_pkg;
  localparam int unsigned DEF_ADDR_W   = 4;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_N_SW     = 6;
  localparam int unsigned DEF_N_MON    = 3;
  localparam int unsigned DEF_CFG_ADDR = 5;
  localparam int unsigned DEF_RES_ADDR = 8;

  typedef enum logic {CONV_IDLE = 1'b0, CONV_BUSY = 1'b1} conv_state_e;
endpackage

// File: rtl/anacfg_swdec.sv
module anacfg_swdec #(
  parameter int unsigned N_SW   = 6,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  logic [CODE_W-1:0] code_i,
  output logic [N_SW-1:0]   close_o
);
  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    assign close_o[i] = (code_i == CODE_W'(i + 1));
  end

  p_single_close_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (code_i != '0 && code_i <= CODE_W'(N_SW)) |-> ($countones(close_o) == 1));
  p_none_closed_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (code_i == '0 || code_i > CODE_W'(N_SW)) |-> (close_o == '0));
endmodule

// File: rtl/anacfg_mon.sv
module anacfg_mon #(
  parameter int unsigned N_MON = 3
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic [N_MON-1:0] mux_i,
  input  logic [N_MON-1:0] oe_i,
  input  logic [N_MON-1:0] cmp_i,
  output logic [N_MON-1:0] active_o,
  output logic [N_MON-1:0] drv_o
);
  for (genvar i = 0; i < N_MON; i++) begin : g_pin
    assign active_o[i] = mux_i[i] & oe_i[i];
    assign drv_o[i]    = active_o[i] & cmp_i[i];

    p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_ok)
      !oe_i[i] |-> (!active_o[i] && !drv_o[i]));
  end
endmodule

// File: rtl/anacfg_conv.sv
module anacfg_conv
  import anacfg_pkg::*;
#(
  parameter int unsigned RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             trig_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] data_i,
  output logic             start_o,
  output logic [RES_W-1:0] result_o
);
  conv_state_e      state_q, state_d;
  logic             start_q, start_d;
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    res_d   = res_q;
    if (state_q == CONV_BUSY) begin
      if (done_i) begin
        state_d = CONV_IDLE;
        res_d   = data_i;
      end
    end else if (trig_i) begin
      state_d = CONV_BUSY;
      start_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q <= CONV_IDLE;
      start_q <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      res_q   <= res_d;
    end
  end

  assign start_o  = start_q;
  assign result_o = res_q;

  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    start_q |=> !start_q);
  p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == CONV_BUSY && trig_i) |=> !start_q);
  p_done_frees_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == CONV_BUSY && done_i) |=> (state_q == CONV_IDLE));
  p_idle_done_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == CONV_IDLE) |=> $stable(res_q));
endmodule

// File: rtl/anacfg_regs.sv
module anacfg_regs
  import anacfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned N_SW     = DEF_N_SW,
  parameter int unsigned N_MON    = DEF_N_MON,
  parameter int unsigned CFG_ADDR = DEF_CFG_ADDR,
  parameter int unsigned RES_ADDR = DEF_RES_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_MON-1:0]  cmp_in,
  input  logic [N_MON-1:0]  pin_oe,
  output logic [N_SW-1:0]   sw_close,
  output logic [N_MON-1:0]  mon_active,
  output logic [N_MON-1:0]  mon_out,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data
);
  localparam int unsigned CODE_W    = $clog2(N_SW + 1);
  localparam int unsigned MUX_LSB   = CODE_W;
  localparam int unsigned START_BIT = DATA_W - 1;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // write decode
  logic cfg_hit, res_hit, cfg_wr, trig;
  assign cfg_hit = (bus_addr == ADDR_W'(CFG_ADDR));
  assign res_hit = (bus_addr == ADDR_W'(RES_ADDR));
  assign cfg_wr  = bus_we && cfg_hit;
  assign trig    = (cfg_wr && bus_wdata[START_BIT]) || (bus_we && res_hit);

  // write-only configuration fields
  logic [CODE_W-1:0] code_q, code_d;
  logic [N_MON-1:0]  mux_q, mux_d;

  always_comb begin
    code_d = code_q;
    mux_d  = mux_q;
    if (cfg_wr) begin
      code_d = bus_wdata[CODE_W-1:0];
      mux_d  = bus_wdata[MUX_LSB +: N_MON];
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      code_q <= '0;
      mux_q  <= '0;
    end else if (cfg_wr) begin
      code_q <= code_d;
      mux_q  <= mux_d;
    end
  end

  anacfg_swdec #(.N_SW(N_SW), .CODE_W(CODE_W)) u_swdec (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .code_i  (code_q),
    .close_o (sw_close)
  );

  anacfg_mon #(.N_MON(N_MON)) u_mon (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .mux_i    (mux_q),
    .oe_i     (pin_oe),
    .cmp_i    (cmp_in),
    .active_o (mon_active),
    .drv_o    (mon_out)
  );

  logic [DATA_W-1:0] result;

  anacfg_conv #(.RES_W(DATA_W)) u_conv (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .trig_i   (trig),
    .done_i   (conv_done),
    .data_i   (conv_data),
    .start_o  (conv_start),
    .result_o (result)
  );

  // read path: write-only fields read as zero
  always_comb begin
    bus_rdata = '0;
    if (cfg_hit) bus_rdata[MUX_LSB +: N_MON] = cmp_in;
    else if (res_hit) bus_rdata = result;
  end

  p_rd_cfg_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_hit |-> (bus_rdata[START_BIT] == 1'b0 && bus_rdata[CODE_W-1:0] == '0));
  p_stray_wr_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_we && !cfg_hit && !res_hit) |=> ($stable(sw_close) && !conv_start));
endmodule

// File: tb/tb_anacfg_regs.sv
module tb_anacfg_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata;
  logic [2:0] cmp_in, pin_oe, mon_active, mon_out;
  logic [5:0] sw_close;
  logic       conv_start, conv_done;
  logic [7:0] conv_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  anacfg_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cmp_in(cmp_in), .pin_oe(pin_oe),
    .sw_close(sw_close), .mon_active(mon_active), .mon_out(mon_out),
    .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic done_pulse(input logic [7:0] d);
    @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(posedge clk); #1;
    conv_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    cmp_in = '0; pin_oe = '1; conv_done = 1'b0; conv_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R9 reset state
    @(negedge clk);
    check(sw_close, 0, "R9 switches open");
    check(mon_active, 0, "R9 mux clear");
    check(conv_start, 0, "R9 no start");
    rd(4'd8, r);
    check(r, 0, "R9 result zero");

    // R1 R2 switch code sweep
    for (int c = 0; c < 8; c++) begin
      wr(4'd5, 8'(c));
      if (c >= 1 && c <= 6) check(sw_close, 32'(1 << (c - 1)), "R1 one switch");
      else                  check(sw_close, 0, "R2 no switch");
      check(conv_start, 0, "R5 no start without bit");
    end

    // R3 mux x oe x cmp sweep, R4 read-back
    for (int m = 0; m < 8; m++) begin
      wr(4'd5, 8'(m << 3));
      for (int o = 0; o < 8; o++) begin
        for (int k = 0; k < 8; k++) begin
          @(negedge clk);
          pin_oe = 3'(o); cmp_in = 3'(k); #1;
          check(mon_active, 32'(m & o), "R3 active");
          check(mon_out, 32'(m & o & k), "R3 level");
        end
      end
      rd(4'd5, r);
      check(r, 32'(k_of(cmp_in) << 3), "R4 cfg read");
    end

    // R10 stray write
    wr(4'd5, 8'h02);
    wr(4'd3, 8'hFF);
    check(sw_close, 6'b000010, "R10 switches kept");
    check(conv_start, 0, "R10 no start");
    pin_oe = '1; cmp_in = '1;
    @(negedge clk);
    check(mon_active, 0, "R10 mux kept");

    // R5 start via bit 7
    wr(4'd5, 8'h80);
    check(conv_start, 1, "R5 pulse");
    @(negedge clk);
    check(conv_start, 0, "R5 one cycle");
    // R7 busy drops requests
    wr(4'd5, 8'h80);
    check(conv_start, 0, "R7 cfg start dropped");
    wr(4'd8, 8'h00);
    check(conv_start, 0, "R7 result-write dropped");
    rd(4'd5, r);
    check(r[7], 0, "R4 start reads zero");
    // R8 done captures
    done_pulse(8'hA5);
    rd(4'd8, r);
    check(r, 8'hA5, "R8 captured");
    done_pulse(8'h3C);
    rd(4'd8, r);
    check(r, 8'hA5, "R8 idle done ignored");
    // R6 start via result address
    wr(4'd8, 8'h00);
    check(conv_start, 1, "R6 pulse");
    @(negedge clk);
    check(conv_start, 0, "R6 one cycle");
    done_pulse(8'h5A);
    rd(4'd8, r);
    check(r, 8'h5A, "R8 second capture");
    wr(4'd5, 8'h80);
    check(conv_start, 1, "R8 idle again after done");
    done_pulse(8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int k_of(input logic [2:0] v);
    return int'(v);
  endfunction
endmodule